// File: doc/BRIEF.md
# NAND ECC Register Front End

This block is the software-visible side of a Reed-Solomon ECC engine in a NAND flash controller. A processor reaches it over a simple 32-bit register bus with a byte address, byte enables, separate read and write strobes, and read data that is registered. Control writes are turned into level controls and single-cycle strobes for the engine: enable, Reed-Solomon mode, direction, engine reset, start and parity-ready. Finish, error and error-report events from the engine are collected into sticky status flags that software clears, into a bank of error-report words, and into an interrupt output gated by a mask.

The ECC unit covers 512 data bytes with 9 parity bytes. These bytes sit in a byte-addressable parity store. The engine loads the store when an encode finishes, and software reads it back. Before a decode, software writes the stored parity and then sets parity-ready, which tells the engine that the parity is valid. When a decode finishes, the number of correctable errors is packed into the top three bits of the status word.

Top module: `nand_ecc_regs`

## Requirements
- R1: After synchronous reset every register reads 0, `irq` is low and all engine controls and strobes are low.
- R2: Control register at byte address 0x00. Bit 0 enable, bit 2 Reed-Solomon mode and bit 3 encode (1) or decode (0) are stored, read back, and drive `eng_enable`, `eng_rs` and `eng_encode`. Bits 1 and 4 always read 0. Only byte lane 0 is written.
- R3: A control write with bit 1 set gives a one-cycle `eng_reset` pulse. The same write clears the whole status word and all parity bytes.
- R4: `eng_start` pulses for one cycle after a control write with bit 0 set, when enable was clear before the write or bit 1 is also set.
- R5: `eng_par_ready` pulses for one cycle after a control write with bit 4 = 1, bit 0 = 1 and bit 3 = 0. In encode mode, bit 4 has no effect.
- R6: Status word at 0x14: bit 0 error, bit 1 uncorrectable, bit 2 encode finished, bit 3 decode finished, bit 4 pad finished, bits 31:29 correctable error count. A decode finish with an error report loads the count and sets bit 0. An uncorrectable report sets bits 0 and 1.
- R7: Engine finish and report inputs are ignored while enable is clear.
- R8: Status flags stay set until software clears them. A status write ANDs each enabled byte lane with the written data, so writing zero clears everything. Lane 0 holds the flags and lane 3 holds the count.
- R9: Parity byte k (0 to 8) is at byte address 0x08+k, in lane address[1:0], and is written under its byte enable. When an encode finishes, byte k is loaded from `eng_par_in[8k+7:8k]`. `eng_par_out` always presents the store.
- R10: Error report i is at 0x1C+4i and is written only by the engine through `eng_rpt_we`/`eng_rpt_idx`. Software writes to it have no effect.
- R11: Clearing enable leaves the parity store and the error reports unchanged.
- R12: Interrupt mask at 0x18, bits 4:0. `irq` rises one cycle after a status flag set in the mask becomes visible, and falls after those flags are cleared.
- R13: Read data appears one cycle after the read strobe. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| eng_enable | output | 1 | Engine enable level |
| eng_rs | output | 1 | Reed-Solomon mode select |
| eng_encode | output | 1 | 1 = encode, 0 = decode |
| eng_reset | output | 1 | One-cycle engine reset strobe |
| eng_start | output | 1 | One-cycle start strobe |
| eng_par_ready | output | 1 | One-cycle parity-valid strobe for decode |
| eng_par_out | output | 8*PAR_BYTES | Parity store contents |
| eng_enc_done | input | 1 | Encode finished pulse |
| eng_dec_done | input | 1 | Decode finished pulse |
| eng_pad_done | input | 1 | Padding finished pulse |
| eng_err | input | 1 | Error seen, valid with decode finish |
| eng_uncor | input | 1 | Uncorrectable, valid with decode finish |
| eng_err_cnt | input | 3 | Correctable error count, valid with decode finish |
| eng_par_in | input | 8*PAR_BYTES | Computed parity, valid with encode finish |
| eng_rpt_we | input | 1 | Error report write strobe |
| eng_rpt_idx | input | RPT_IDX_W | Error report slot |
| eng_rpt_data | input | 32 | Error report word |
| irq | output | 1 | Masked status interrupt |

## Verification
The bench targets the self-clearing control bits. A design that stored bit 1 or bit 4 would read them back as 1 and would repeat the strobe on the next read-modify-write. It also checks that start fires only on an enable edge or with reset, and that parity-ready is refused in encode mode. A design that got these wrong would restart a running engine or finish a decode early. Status clearing is tested lane by lane: a partial write must clear the flags and keep the count. Engine events arrive while enable is clear and must leave no trace. The parity store and error reports must survive the enable bit being dropped, because the driver reads them only after it has turned the engine off.

// File: rtl/nec_pkg.sv
package nec_pkg;
  // byte offsets of the register map
  localparam int OFS_CTRL = 'h00;
  localparam int OFS_PAR  = 'h08;
  localparam int OFS_STAT = 'h14;
  localparam int OFS_MASK = 'h18;
  localparam int OFS_RPT  = 'h1C;
  // control bits
  localparam int CB_EN   = 0;
  localparam int CB_RST  = 1;
  localparam int CB_RS   = 2;
  localparam int CB_ENC  = 3;
  localparam int CB_PRDY = 4;
  // status layout
  localparam int FLAG_W  = 5;
  localparam int CNT_W   = 3;
  localparam int CNT_LSB = 29;

  typedef struct packed {
    logic pad;
    logic dec;
    logic enc;
    logic unc;
    logic err;
  } nec_flags_t;
endpackage

// File: rtl/nec_ctrl.sv
module nec_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [4:0] wbits,
  output logic       en,
  output logic       rs,
  output logic       enc,
  output logic       rst_pulse,
  output logic       start_pulse,
  output logic       prdy_pulse,
  output logic [4:0] rd_bits
);
  import nec_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      en          <= 1'b0;
      rs          <= 1'b0;
      enc         <= 1'b0;
      rst_pulse   <= 1'b0;
      start_pulse <= 1'b0;
      prdy_pulse  <= 1'b0;
    end else begin
      rst_pulse   <= 1'b0;
      start_pulse <= 1'b0;
      prdy_pulse  <= 1'b0;
      if (wr) begin
        en          <= wbits[CB_EN];
        rs          <= wbits[CB_RS];
        enc         <= wbits[CB_ENC];
        rst_pulse   <= wbits[CB_RST];
        start_pulse <= wbits[CB_EN] && (wbits[CB_RST] || !en);
        prdy_pulse  <= wbits[CB_PRDY] && wbits[CB_EN] && !wbits[CB_ENC];
      end
    end
  end

  // self-clearing bits read as zero
  always_comb begin
    rd_bits         = '0;
    rd_bits[CB_EN]  = en;
    rd_bits[CB_RS]  = rs;
    rd_bits[CB_ENC] = enc;
  end
endmodule

// File: rtl/nec_status.sv
module nec_status (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        active,
  input  logic        wr,
  input  logic        be_lo,
  input  logic        be_hi,
  input  logic [4:0]  wflags,
  input  logic [2:0]  wcnt,
  input  logic        ev_enc,
  input  logic        ev_dec,
  input  logic        ev_pad,
  input  logic        ev_err,
  input  logic        ev_unc,
  input  logic [2:0]  ev_cnt,
  input  logic        mask_wr,
  input  logic [4:0]  mask_wdata,
  output logic [31:0] stat_word,
  output logic [31:0] mask_word,
  output logic        irq
);
  import nec_pkg::*;

  nec_flags_t           flags_q, flags_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [FLAG_W-1:0]    mask_q;

  always_comb begin
    flags_d = flags_q;
    cnt_d   = cnt_q;
    if (wr && be_lo) flags_d = nec_flags_t'(flags_q & wflags);
    if (wr && be_hi) cnt_d   = cnt_q & wcnt;
    if (active) begin
      if (ev_enc) flags_d.enc = 1'b1;
      if (ev_pad) flags_d.pad = 1'b1;
      if (ev_dec) begin
        flags_d.dec = 1'b1;
        if (ev_err || ev_unc) flags_d.err = 1'b1;
        if (ev_unc) flags_d.unc = 1'b1;
        if (ev_err) cnt_d = ev_cnt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      flags_q <= '0;
      cnt_q   <= '0;
    end else begin
      flags_q <= flags_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      irq    <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= mask_wdata;
      irq <= |(flags_q & mask_q);
    end
  end

  always_comb begin
    stat_word = '0;
    stat_word[FLAG_W-1:0] = flags_q;
    stat_word[CNT_LSB +: CNT_W] = cnt_q;
    mask_word = '0;
    mask_word[FLAG_W-1:0] = mask_q;
  end
endmodule

// File: rtl/nec_parity.sv
module nec_parity #(
  parameter int PAR_BYTES = 9,
  parameter int PAR_BASE  = 8,
  parameter int WA_W      = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   wr,
  input  logic [WA_W-1:0]        wr_word,
  input  logic [3:0]             be,
  input  logic [31:0]            wdata,
  input  logic                   load,
  input  logic [8*PAR_BYTES-1:0] load_data,
  input  logic [WA_W-1:0]        rd_word_addr,
  output logic [31:0]            rd_word,
  output logic [8*PAR_BYTES-1:0] par_out
);
  logic [7:0] pb [PAR_BYTES];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int k = 0; k < PAR_BYTES; k++) pb[k] <= '0;
    end else if (load) begin
      for (int k = 0; k < PAR_BYTES; k++) pb[k] <= load_data[8*k +: 8];
    end else if (wr) begin
      for (int k = 0; k < PAR_BYTES; k++) begin
        if (wr_word == WA_W'((PAR_BASE + k) / 4) && be[(PAR_BASE + k) % 4])
          pb[k] <= wdata[8*((PAR_BASE + k) % 4) +: 8];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < PAR_BYTES; k++) begin
      if (rd_word_addr == WA_W'((PAR_BASE + k) / 4))
        rd_word[8*((PAR_BASE + k) % 4) +: 8] = pb[k];
    end
  end

  for (genvar g = 0; g < PAR_BYTES; g++) begin : g_out
    assign par_out[8*g +: 8] = pb[g];
  end
endmodule

// File: rtl/nec_errlog.sv
module nec_errlog #(
  parameter int SLOTS    = 4,
  parameter int IDX_W    = 2,
  parameter int RPT_BASE = 'h1C,
  parameter int WA_W     = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]     data,
  input  logic [WA_W-1:0] rd_word_addr,
  output logic [31:0]     rd_word
);
  logic [31:0] slot [SLOTS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) slot[i] <= '0;
    end else if (we) begin
      for (int i = 0; i < SLOTS; i++)
        if (idx == IDX_W'(i)) slot[i] <= data;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < SLOTS; i++)
      if (rd_word_addr == WA_W'(RPT_BASE / 4 + i)) rd_word = slot[i];
  end
endmodule

// File: rtl/nand_ecc_regs.sv
module nand_ecc_regs #(
  parameter int ADDR_W    = 8,
  parameter int PAR_BYTES = 9,
  parameter int ERR_SLOTS = 4,
  parameter int RPT_IDX_W = (ERR_SLOTS > 1) ? $clog2(ERR_SLOTS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [3:0]             bus_be,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  output logic                   eng_enable,
  output logic                   eng_rs,
  output logic                   eng_encode,
  output logic                   eng_reset,
  output logic                   eng_start,
  output logic                   eng_par_ready,
  output logic [8*PAR_BYTES-1:0] eng_par_out,
  input  logic                   eng_enc_done,
  input  logic                   eng_dec_done,
  input  logic                   eng_pad_done,
  input  logic                   eng_err,
  input  logic                   eng_uncor,
  input  logic [2:0]             eng_err_cnt,
  input  logic [8*PAR_BYTES-1:0] eng_par_in,
  input  logic                   eng_rpt_we,
  input  logic [RPT_IDX_W-1:0]   eng_rpt_idx,
  input  logic [31:0]            eng_rpt_data,
  output logic                   irq
);
  import nec_pkg::*;

  localparam int WA_W = ADDR_W - 2;

  logic [WA_W-1:0] word;
  logic            hit_ctrl, hit_stat, hit_mask;
  logic            wr_ctrl, soft_clr, wr_stat, wr_mask;
  logic [4:0]      ctrl_bits;
  logic [31:0]     stat_word, mask_word, par_rd, rpt_rd;
  logic            unused_addr;

  assign word        = bus_addr[ADDR_W-1:2];
  assign unused_addr = ^bus_addr[1:0];
  assign hit_ctrl    = (word == WA_W'(OFS_CTRL / 4));
  assign hit_stat    = (word == WA_W'(OFS_STAT / 4));
  assign hit_mask    = (word == WA_W'(OFS_MASK / 4));
  assign wr_ctrl     = bus_wr && hit_ctrl && bus_be[0];
  assign soft_clr    = wr_ctrl && bus_wdata[CB_RST];
  assign wr_stat     = bus_wr && hit_stat;
  assign wr_mask     = bus_wr && hit_mask && bus_be[0];

  nec_ctrl ctrl_i (
    .clk(clk), .rst(rst), .wr(wr_ctrl), .wbits(bus_wdata[4:0]),
    .en(eng_enable), .rs(eng_rs), .enc(eng_encode),
    .rst_pulse(eng_reset), .start_pulse(eng_start), .prdy_pulse(eng_par_ready),
    .rd_bits(ctrl_bits)
  );

  nec_status stat_i (
    .clk(clk), .rst(rst), .clr(soft_clr), .active(eng_enable),
    .wr(wr_stat), .be_lo(bus_be[0]), .be_hi(bus_be[3]),
    .wflags(bus_wdata[4:0]), .wcnt(bus_wdata[31:29]),
    .ev_enc(eng_enc_done), .ev_dec(eng_dec_done), .ev_pad(eng_pad_done),
    .ev_err(eng_err), .ev_unc(eng_uncor), .ev_cnt(eng_err_cnt),
    .mask_wr(wr_mask), .mask_wdata(bus_wdata[4:0]),
    .stat_word(stat_word), .mask_word(mask_word), .irq(irq)
  );

  nec_parity #(.PAR_BYTES(PAR_BYTES), .PAR_BASE(OFS_PAR), .WA_W(WA_W)) par_i (
    .clk(clk), .rst(rst), .clr(soft_clr), .wr(bus_wr), .wr_word(word),
    .be(bus_be), .wdata(bus_wdata),
    .load(eng_enable && eng_enc_done), .load_data(eng_par_in),
    .rd_word_addr(word), .rd_word(par_rd), .par_out(eng_par_out)
  );

  nec_errlog #(.SLOTS(ERR_SLOTS), .IDX_W(RPT_IDX_W), .RPT_BASE(OFS_RPT), .WA_W(WA_W)) log_i (
    .clk(clk), .rst(rst), .we(eng_enable && eng_rpt_we), .idx(eng_rpt_idx),
    .data(eng_rpt_data), .rd_word_addr(word), .rd_word(rpt_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= (hit_ctrl ? {27'd0, ctrl_bits} : 32'd0)
                 | (hit_stat ? stat_word : 32'd0)
                 | (hit_mask ? mask_word : 32'd0)
                 | par_rd | rpt_rd;
    end
  end
endmodule

// File: rtl/nec_checker.sv
module nec_checker #(
  parameter int PAR_BYTES = 9
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   soft_clr,
  input logic                   wr_stat,
  input logic                   bus_wr,
  input logic                   eng_enable,
  input logic                   eng_encode,
  input logic                   eng_reset,
  input logic                   eng_start,
  input logic                   eng_par_ready,
  input logic                   eng_enc_done,
  input logic [8*PAR_BYTES-1:0] eng_par_out,
  input logic [31:0]            stat_word,
  input logic                   irq
);
  p_reset_single_r3: assert property (@(posedge clk) disable iff (rst)
    eng_reset && !soft_clr |=> !eng_reset);
  p_soft_clear_r3: assert property (@(posedge clk) disable iff (rst)
    soft_clr |=> (stat_word == 32'd0 && eng_par_out == '0));
  p_start_enabled_r4: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> eng_enable);
  p_prdy_decode_r5: assert property (@(posedge clk) disable iff (rst)
    eng_par_ready |-> (eng_enable && !eng_encode));
  p_idle_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    !eng_enable && !wr_stat && !soft_clr |=> $stable(stat_word));
  p_enc_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    stat_word[2] && !wr_stat && !soft_clr |=> stat_word[2]);
  p_parity_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !bus_wr && !eng_enc_done && !soft_clr |=> $stable(eng_par_out));
  p_irq_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    stat_word[4:0] == 5'd0 |=> !irq);
endmodule

bind nand_ecc_regs nec_checker #(.PAR_BYTES(PAR_BYTES)) chk_i (
  .clk(clk), .rst(rst), .soft_clr(soft_clr), .wr_stat(wr_stat), .bus_wr(bus_wr),
  .eng_enable(eng_enable), .eng_encode(eng_encode), .eng_reset(eng_reset),
  .eng_start(eng_start), .eng_par_ready(eng_par_ready), .eng_enc_done(eng_enc_done),
  .eng_par_out(eng_par_out), .stat_word(stat_word), .irq(irq)
);

// File: tb/nand_ecc_regs_tb_top.sv
module nand_ecc_regs_tb_top;
  localparam int PB = 9;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst;
  logic [7:0]    bus_addr;
  logic          bus_wr, bus_rd;
  logic [3:0]    bus_be;
  logic [31:0]   bus_wdata, bus_rdata;
  logic          eng_enable, eng_rs, eng_encode, eng_reset, eng_start, eng_par_ready;
  logic [8*PB-1:0] eng_par_out, eng_par_in;
  logic          eng_enc_done, eng_dec_done, eng_pad_done, eng_err, eng_uncor;
  logic [2:0]    eng_err_cnt;
  logic          eng_rpt_we;
  logic [1:0]    eng_rpt_idx;
  logic [31:0]   eng_rpt_data;
  logic          irq;

  nand_ecc_regs dut_i (.*);

  int n_chk = 0, n_fail = 0;
  int n_start = 0, n_rst = 0, n_prdy = 0;

  always @(negedge clk) begin
    if (eng_start) n_start++;
    if (eng_reset) n_rst++;
    if (eng_par_ready) n_prdy++;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'h0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, bus_rdata, exp);
  endtask

  task automatic ev(logic enc, logic dec, logic pad, logic err, logic unc, logic [2:0] cnt);
    @(negedge clk);
    eng_enc_done = enc; eng_dec_done = dec; eng_pad_done = pad;
    eng_err = err; eng_uncor = unc; eng_err_cnt = cnt;
    @(negedge clk);
    eng_enc_done = 0; eng_dec_done = 0; eng_pad_done = 0;
    eng_err = 0; eng_uncor = 0; eng_err_cnt = 0;
  endtask

  task automatic rpt(logic [1:0] idx, logic [31:0] d);
    @(negedge clk);
    eng_rpt_we = 1'b1; eng_rpt_idx = idx; eng_rpt_data = d;
    @(negedge clk);
    eng_rpt_we = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 enable", {31'd0, eng_enable}, 0);
    check("R1 strobes", {29'd0, eng_start, eng_reset, eng_par_ready}, 0);
    check("R1 irq", {31'd0, irq}, 0);
    rd_chk("R1 ctrl", 8'h00, 0);
    rd_chk("R1 status", 8'h14, 0);
    rd_chk("R1 parity", 8'h08, 0);
    rd_chk("R1 report", 8'h1C, 0);
  endtask

  task automatic t_ctrl;
    wr(8'h00, 32'h0D);
    @(negedge clk);
    check("R2 eng outs", {29'd0, eng_enable, eng_rs, eng_encode}, 3'b111);
    check("R4 start on enable edge", n_start, 1);
    rd_chk("R2 readback", 8'h00, 32'h0D);
    wr(8'h00, 32'h1D);
    @(negedge clk);
    check("R5 no parity-ready in encode", n_prdy, 0);
    check("R4 no start when already enabled", n_start, 1);
    rd_chk("R2 bit4 reads 0", 8'h00, 32'h0D);
    wr(8'h00, 32'h07);
    @(negedge clk);
    check("R3 reset strobe", n_rst, 1);
    check("R4 start with reset", n_start, 2);
    rd_chk("R2 bit1 reads 0", 8'h00, 32'h05);
    wr(8'h00, 32'h15);
    @(negedge clk);
    check("R5 parity-ready in decode", n_prdy, 1);
    check("R4 no start", n_start, 2);
    wr(8'h00, 32'h0, 4'h0);
    rd_chk("R2 lane0 gated", 8'h00, 32'h05);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_encode;
    for (int k = 0; k < PB; k++) eng_par_in[8*k +: 8] = 8'hA0 + 8'(k);
    wr(8'h00, 32'h0F);
    ev(1, 0, 0, 0, 0, 0);
    rd_chk("R6 enc finish", 8'h14, 32'h4);
    rd_chk("R9 par word0", 8'h08, 32'hA3A2A1A0);
    rd_chk("R9 par word1", 8'h0C, 32'hA7A6A5A4);
    rd_chk("R9 par word2", 8'h10, 32'h000000A8);
    check("R9 par out", eng_par_out[71:64], 8'hA8);
    wr(8'h00, 32'h0C);
    rd_chk("R11 parity kept", 8'h0C, 32'hA7A6A5A4);
    rd_chk("R8 sticky", 8'h14, 32'h4);
    wr(8'h00, 32'h0E);
    rd_chk("R3 status cleared", 8'h14, 0);
    rd_chk("R3 parity cleared", 8'h08, 0);
  endtask

  task automatic t_sw_parity;
    wr(8'h10, 32'h0000005A, 4'b0001);
    wr(8'h0C, 32'h12AB3456, 4'b0100);
    rd_chk("R9 lane write", 8'h0C, 32'h00AB0000);
    rd_chk("R9 last byte", 8'h10, 32'h5A);
    check("R9 par out byte6", eng_par_out[55:48], 8'hAB);
  endtask

  task automatic t_decode;
    wr(8'h00, 32'h07);
    rpt(0, 32'h00120034);
    rpt(1, 32'h00560078);
    ev(0, 1, 0, 1, 0, 3'd2);
    rd_chk("R6 decode with count", 8'h14, 32'h40000009);
    rd_chk("R10 report0", 8'h1C, 32'h00120034);
    rd_chk("R10 report1", 8'h20, 32'h00560078);
    wr(8'h20, 32'hFFFFFFFF);
    rd_chk("R10 sw write ignored", 8'h20, 32'h00560078);
    wr(8'h14, 32'hFFFFFFF7);
    rd_chk("R8 and-clear one flag", 8'h14, 32'h40000001);
    wr(8'h14, 32'h0, 4'b0001);
    rd_chk("R8 lane0 only", 8'h14, 32'h40000000);
    wr(8'h14, 32'h0);
    rd_chk("R8 zero clears", 8'h14, 0);
    ev(0, 1, 0, 0, 1, 0);
    rd_chk("R6 uncorrectable", 8'h14, 32'h0000000B);
    wr(8'h14, 32'h0);
    wr(8'h00, 32'h04);
    rd_chk("R11 report kept", 8'h1C, 32'h00120034);
  endtask

  task automatic t_disabled;
    ev(1, 1, 1, 1, 0, 3'd5);
    rpt(2, 32'hDEADBEEF);
    rd_chk("R7 status untouched", 8'h14, 0);
    rd_chk("R7 report untouched", 8'h24, 0);
  endtask

  task automatic t_irq;
    wr(8'h00, 32'h07);
    wr(8'h18, 32'h08);
    rd_chk("R12 mask", 8'h18, 32'h08);
    ev(0, 0, 1, 0, 0, 0);
    @(negedge clk);
    check("R12 unmasked flag", {31'd0, irq}, 0);
    ev(0, 1, 0, 0, 0, 0);
    @(negedge clk);
    check("R12 masked flag", {31'd0, irq}, 1);
    wr(8'h14, 32'h0);
    @(negedge clk);
    check("R12 cleared", {31'd0, irq}, 0);
  endtask

  task automatic t_unmapped;
    rd_chk("R13 hole 0x04", 8'h04, 0);
    rd_chk("R13 hole 0x40", 8'h40, 0);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1; bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_be = 0; bus_wdata = 0;
    eng_enc_done = 0; eng_dec_done = 0; eng_pad_done = 0; eng_err = 0; eng_uncor = 0;
    eng_err_cnt = 0; eng_par_in = '0; eng_rpt_we = 0; eng_rpt_idx = 0; eng_rpt_data = 0;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_encode();
    t_sw_parity();
    t_decode();
    t_disabled();
    t_irq();
    t_unmapped();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule